// File: doc/BRIEF.md
# SPI Flash Read Controller with APB Register Access

This block sits on an APB bus and fetches data from a serial flash device over a single-bit SPI link. Software first sets up the block. It writes a clock divider, a format word and a transfer-control word that selects which phases run and how many bytes to fetch. It then loads a 24-bit flash address and writes the opcode to the command register. That command write launches the serial transaction. The block asserts chip select, shifts out the opcode and the address, and then clocks in the requested bytes.

Received bytes are packed four to a 32-bit word, with the first byte in the low lane. Each word goes into a small receive FIFO. Software collects the words by reading the data register repeatedly. A read of an empty FIFO is stretched with wait states until a word arrives, so software can start reading as soon as the command has been issued. A status bit shows that a transaction is still running. A control-register bit flushes stale words out of the FIFO.

Top module: `spird_top`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high, `spi_sclk` is low, and reads of the status register (0x34), transfer-control register (0x20) and timing register (0x40) return 0.
- R2: Writes complete with no wait states. Offsets 0x10 (format, 32 bits), 0x20 (transfer control, 32 bits), 0x28 (address, 32 bits) and 0x40 (timing, low 8 bits) read back what was written. Unimplemented offsets, including 0x38, 0x3C and 0x7C, read as 0.
- R3: A write to offset 0x24 starts a transaction if any phase is enabled. Chip select goes low, and the low 8 bits of the write go out MSB first when transfer-control bit 30 is set. The low 24 bits of the address register then follow, MSB first, when bit 29 is set.
- R4: The read phase runs only when transfer-control bits 27:24 equal 2. It then fetches (bits 8:0)+1 bytes. With any other mode value, chip select rises after the header bits alone.
- R5: The link uses SPI mode 0. SCLK idles low and is low whenever chip select is high. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge, MSB of each byte first.
- R6: SCLK high and low phases each last (timing[7:0]+1) PCLK cycles, so one SCLK period is 2·(timing+1) PCLK cycles.
- R7: Bytes are packed little-endian, with the first received byte in bits 7:0. A final word holding fewer than four bytes has its unused upper bytes set to 0.
- R8: Each completed read of the data register (0x2C) removes one word from the receive FIFO and returns the words in arrival order.
- R9: A read of 0x2C while the FIFO is empty holds PREADY low until a word is available, and then returns that word. No other access ever sees PREADY low.
- R10: Status bit 0 reads 1 from the cycle after the command write until chip select returns high, and reads 0 otherwise.
- R11: A command write while a transaction is in progress is ignored. No second transaction starts and the stored opcode does not change.
- R12: Writing control register 0x30 with bit 1 set discards every word held in the receive FIFO.
- R13: When the FIFO is full, SCLK stays low before the next sampling edge until a word is popped. No received byte is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Asynchronous reset, active low |
| paddr | input | 8 | APB byte address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low only for a data read of an empty FIFO |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume a well-formed APB master. A setup phase precedes every access phase, and address, direction and select are held while PREADY is low. The bench's single access task does this by construction. The bench holds `spi_miso` steady and changes it only on falling SCLK edges, so the rising-edge sampling sees settled data. It never writes the timing or transfer-control words while a transaction is running. The FIFO-overflow property relies on the sequencer pausing the serial clock, so that check covers the stall path in R13 as well.

// File: rtl/spird_pkg.sv
package spird_pkg;
    // register offsets decoded on paddr
    localparam logic [7:0] OFS_FMT  = 8'h10;
    localparam logic [7:0] OFS_XCTL = 8'h20;
    localparam logic [7:0] OFS_OPC  = 8'h24;
    localparam logic [7:0] OFS_ADR  = 8'h28;
    localparam logic [7:0] OFS_DAT  = 8'h2C;
    localparam logic [7:0] OFS_CTL  = 8'h30;
    localparam logic [7:0] OFS_STS  = 8'h34;
    localparam logic [7:0] OFS_TIM  = 8'h40;

    // transfer-control field positions
    localparam int XC_CMD_BIT  = 30;
    localparam int XC_ADR_BIT  = 29;
    localparam int XC_MODE_LO  = 24;
    localparam int CTL_FLUSH   = 1;
    localparam logic [3:0] MODE_RDONLY = 4'd2;

    // header lengths in bits
    localparam int OPC_BITS = 8;
    localparam int ADR_BITS = 24;
endpackage

// File: rtl/spird_fifo.sv
module spird_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PTRW-1:0] PTR_LAST = PTRW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t        st_d, st_q;
    logic [DW-1:0]   mem_q [DEPTH];
    logic            do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_FULL);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/spird_seq.sv
module spird_seq #(
    parameter int DIVW = 8,
    parameter int CNTW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [23:0]     addr,
    input  logic            cmd_en,
    input  logic            addr_en,
    input  logic            rd_en,
    input  logic [CNTW-1:0] rd_cnt,
    input  logic [DIVW-1:0] div,
    input  logic            fifo_full,
    input  logic            miso,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi,
    output logic            busy,
    output logic            push,
    output logic [31:0]     push_word
);
    import spird_pkg::*;

    localparam int IDXW = CNTW + 4;

    typedef struct packed {
        logic            busy;
        logic            sclk;
        logic            cs_n;
        logic [31:0]     sh;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] hdr;
        logic [IDXW-1:0] last;
        logic [DIVW-1:0] tcnt;
        logic [31:0]     acc;
        logic [1:0]      lane;
        logic [2:0]      bcnt;
        logic [7:0]      byt;
    } seq_st_t;

    seq_st_t         st_d, st_q;
    logic [IDXW-1:0] hdr_bits, rd_bits, tot_bits;
    logic [7:0]      byt_new;
    logic [31:0]     word_new;
    logic            in_read, stall;

    assign hdr_bits = (cmd_en  ? IDXW'(OPC_BITS) : '0)
                    + (addr_en ? IDXW'(ADR_BITS) : '0);
    assign rd_bits  = rd_en ? ((IDXW'(rd_cnt) + 1'b1) << 3) : '0;
    assign tot_bits = hdr_bits + rd_bits;

    assign in_read  = (st_q.idx >= st_q.hdr);
    assign stall    = !st_q.sclk && fifo_full && in_read;
    assign byt_new  = {st_q.byt[6:0], miso};
    assign word_new = st_q.acc | ({24'b0, byt_new} << {st_q.lane, 3'b000});

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_word = word_new;
        if (!st_q.busy) begin
            if (start && tot_bits != '0) begin
                st_d.busy = 1'b1;
                st_d.cs_n = 1'b0;
                st_d.sclk = 1'b0;
                st_d.tcnt = '0;
                st_d.idx  = '0;
                st_d.hdr  = hdr_bits;
                st_d.last = tot_bits - 1'b1;
                st_d.sh   = cmd_en ? {opcode, addr} : {addr, 8'h00};
                st_d.acc  = '0;
                st_d.lane = '0;
                st_d.bcnt = '0;
            end
        end else if (!stall) begin
            if (st_q.tcnt != div) begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end else begin
                st_d.tcnt = '0;
                if (!st_q.sclk) begin
                    // rising edge: sample during the read phase
                    st_d.sclk = 1'b1;
                    if (in_read) begin
                        st_d.byt  = byt_new;
                        st_d.bcnt = st_q.bcnt + 1'b1;
                        if (st_q.bcnt == 3'd7) begin
                            if (st_q.lane == 2'd3 || st_q.idx == st_q.last) begin
                                push      = 1'b1;
                                st_d.acc  = '0;
                                st_d.lane = '0;
                            end else begin
                                st_d.acc  = word_new;
                                st_d.lane = st_q.lane + 1'b1;
                            end
                        end
                    end
                end else begin
                    // falling edge: advance or finish
                    st_d.sclk = 1'b0;
                    if (st_q.idx == st_q.last) begin
                        st_d.busy = 1'b0;
                        st_d.cs_n = 1'b1;
                        st_d.sh   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.sh  = {st_q.sh[30:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;
    assign cs_n = st_q.cs_n;
    assign mosi = st_q.sh[31];
    assign busy = st_q.busy;
endmodule

// File: rtl/spird_regs.sv
module spird_regs #(
    parameter int DIVW = 8,
    parameter int CNTW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      paddr,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [31:0]     pwdata,
    output logic [31:0]     prdata,
    output logic            pready,
    input  logic            seq_busy,
    input  logic            fifo_empty,
    input  logic [31:0]     fifo_rdata,
    output logic            fifo_pop,
    output logic            fifo_clr,
    output logic            start,
    output logic [7:0]      opcode,
    output logic [23:0]     addr,
    output logic            cmd_en,
    output logic            addr_en,
    output logic            rd_en,
    output logic [CNTW-1:0] rd_cnt,
    output logic [DIVW-1:0] div
);
    import spird_pkg::*;

    typedef struct packed {
        logic [31:0]     fmt;
        logic [31:0]     xctl;
        logic [7:0]      opc;
        logic [31:0]     adr;
        logic [DIVW-1:0] tim;
        logic            start;
        logic            clr;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_acc, rd_dat;

    assign wr_acc   = psel && penable && pwrite;
    assign rd_dat   = psel && !pwrite && (paddr == OFS_DAT);
    assign pready   = !(rd_dat && fifo_empty);
    assign fifo_pop = rd_dat && penable && !fifo_empty;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.clr   = 1'b0;
        if (wr_acc) begin
            case (paddr)
                OFS_FMT:  st_d.fmt  = pwdata;
                OFS_XCTL: st_d.xctl = pwdata;
                OFS_ADR:  st_d.adr  = pwdata;
                OFS_TIM:  st_d.tim  = pwdata[DIVW-1:0];
                OFS_CTL:  st_d.clr  = pwdata[CTL_FLUSH];
                OFS_OPC: begin
                    if (!seq_busy) begin
                        st_d.opc   = pwdata[7:0];
                        st_d.start = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (paddr)
            OFS_FMT:  prdata = st_q.fmt;
            OFS_XCTL: prdata = st_q.xctl;
            OFS_OPC:  prdata = {24'b0, st_q.opc};
            OFS_ADR:  prdata = st_q.adr;
            OFS_DAT:  prdata = fifo_rdata;
            OFS_STS:  prdata = {31'b0, seq_busy};
            OFS_TIM:  prdata = 32'(st_q.tim);
            default:  prdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start    = st_q.start;
    assign fifo_clr = st_q.clr;
    assign opcode   = st_q.opc;
    assign addr     = st_q.adr[23:0];
    assign cmd_en   = st_q.xctl[XC_CMD_BIT];
    assign addr_en  = st_q.xctl[XC_ADR_BIT];
    assign rd_en    = (st_q.xctl[XC_MODE_LO +: 4] == MODE_RDONLY);
    assign rd_cnt   = st_q.xctl[CNTW-1:0];
    assign div      = st_q.tim;
endmodule

// File: rtl/spird_top.sv
module spird_top #(
    parameter int DIVW       = 8,
    parameter int CNTW       = 9,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic [7:0]  paddr,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic            seq_busy, seq_push, seq_start;
    logic [31:0]     seq_word, fifo_rdata;
    logic            fifo_empty, fifo_full, fifo_pop, fifo_clr;
    logic [7:0]      cfg_opc;
    logic [23:0]     cfg_adr;
    logic            cfg_cmd, cfg_adr_en, cfg_rd;
    logic [CNTW-1:0] cfg_cnt;
    logic [DIVW-1:0] cfg_div;

    spird_regs #(.DIVW(DIVW), .CNTW(CNTW)) u_regs (
        .clk(pclk), .rst_n(presetn),
        .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .seq_busy(seq_busy), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .fifo_clr(fifo_clr), .start(seq_start),
        .opcode(cfg_opc), .addr(cfg_adr), .cmd_en(cfg_cmd), .addr_en(cfg_adr_en),
        .rd_en(cfg_rd), .rd_cnt(cfg_cnt), .div(cfg_div)
    );

    spird_seq #(.DIVW(DIVW), .CNTW(CNTW)) u_seq (
        .clk(pclk), .rst_n(presetn), .start(seq_start),
        .opcode(cfg_opc), .addr(cfg_adr), .cmd_en(cfg_cmd), .addr_en(cfg_adr_en),
        .rd_en(cfg_rd), .rd_cnt(cfg_cnt), .div(cfg_div), .fifo_full(fifo_full),
        .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .busy(seq_busy), .push(seq_push), .push_word(seq_word)
    );

    spird_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(pclk), .rst_n(presetn), .clr(fifo_clr),
        .push(seq_push), .wdata(seq_word), .pop(fifo_pop),
        .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
    );
endmodule

// File: rtl/spird_chk.sv
module spird_chk (
    input logic       pclk,
    input logic       presetn,
    input logic       psel,
    input logic       pwrite,
    input logic [7:0] paddr,
    input logic       pready,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       seq_push,
    input logic       fifo_full,
    input logic       fifo_clr
);
    // R5
    sclk_idle_chk: assert property (@(posedge pclk) disable iff (!presetn)
        spi_cs_n |-> !spi_sclk);

    // R5
    mosi_rise_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R5
    mosi_high_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R9
    wait_only_data_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pready) |-> (!pwrite && paddr == 8'h2C));

    // R13
    no_overflow_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !(seq_push && fifo_full && !fifo_clr));
endmodule

bind spird_top spird_chk u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pready(pready), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .seq_push(seq_push), .fifo_full(fifo_full),
    .fifo_clr(fifo_clr)
);

// File: tb/spird_top_bench.sv
module spird_top_bench;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic [7:0]  paddr = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #4 pclk = ~pclk;

    spird_top u_spird_top (
        .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- behavioural flash model ----------------
    int          bitcnt = 0, frames = 0, hdr_bits = 32;
    logic [31:0] cap = '0;
    int          cyc = 0, last_rise = 0, per = 0;

    function automatic logic [7:0] pat(input logic [23:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge pclk) cyc++;
    always @(negedge spi_cs_n) begin
        bitcnt = 0; cap = '0; frames++;
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (bitcnt < hdr_bits) cap = {cap[30:0], spi_mosi};
            bitcnt++;
            per = cyc - last_rise;
            last_rise = cyc;
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n && bitcnt >= hdr_bits) begin
            int k;
            logic [23:0] b;
            logic [7:0]  v;
            k = bitcnt - hdr_bits;
            b = ((hdr_bits == 32) ? cap[23:0] : 24'h0) + 24'(k / 8);
            v = pat(b);
            spi_miso = v[7 - (k % 8)];
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] r, output int waits);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        waits = 0;
        while (!pready) begin
            @(negedge pclk);
            waits++;
        end
        r = prdata;
        @(posedge pclk);
        #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; int w;
        apb(1'b1, a, d, r, w);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        int w;
        apb(1'b0, a, '0, r, w);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'h1;
        while (s[0]) rd(8'h34, s);
    endtask

    function automatic logic [31:0] exp_word(input logic [23:0] base, input int n, input int j);
        logic [31:0] w;
        w = '0;
        for (int l = 0; l < 4; l++)
            if (4 * j + l < n) w[8*l +: 8] = pat(base + 24'(4 * j + l));
        return w;
    endfunction

    task automatic start_read(input logic [23:0] a, input int n);
        wr(8'h20, 32'h6200_0000 | 32'(n - 1));
        wr(8'h28, {8'h00, a});
        wr(8'h24, 32'h03);
    endtask

    task automatic pop_check(input string req, input logic [23:0] a, input int n);
        logic [31:0] r;
        for (int j = 0; j < (n + 3) / 4; j++) begin
            rd(8'h2C, r);
            check(req, r, exp_word(a, n, j));
        end
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [23:0] adr;
        logic [8:0]  cnt;
        logic [7:0]  div;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{24'h000000, 9'd15, 8'd1},
        '{24'h123456, 9'd4,  8'd0},
        '{24'hFFFFFE, 9'd7,  8'd3},
        '{24'hA5C3F0, 9'd1,  8'd2}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int w, f0;

        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        check("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
        check("R1 sclk", {31'b0, spi_sclk}, 32'h0);
        rd(8'h34, r); check("R1 status", r, 32'h0);
        rd(8'h20, r); check("R1 xctl", r, 32'h0);
        rd(8'h40, r); check("R1 timing", r, 32'h0);

        // R2 init and readback
        wr(8'h40, 32'h1);
        wr(8'h10, 32'h0002_0780);
        rd(8'h10, r); check("R2 fmt", r, 32'h0002_0780);
        rd(8'h40, r); check("R2 timing", r, 32'h1);
        wr(8'h28, 32'hDEAD_BEEF);
        rd(8'h28, r); check("R2 addr", r, 32'hDEAD_BEEF);
        apb(1'b1, 8'h20, 32'h6200_000F, r, w); check("R2 no write wait", 32'(w), 32'h0);
        rd(8'h20, r); check("R2 xctl", r, 32'h6200_000F);
        rd(8'h38, r); check("R2 unmapped 38", r, 32'h0);
        rd(8'h7C, r); check("R2 unmapped 7C", r, 32'h0);

        // vector table: R3 R6 R7 R8
        foreach (VECS[i]) begin
            wr(8'h40, 32'(VECS[i].div));
            start_read(VECS[i].adr, int'(VECS[i].cnt) + 1);
            wait_idle();
            check("R3 opcode", {24'b0, cap[31:24]}, 32'h03);
            check("R3 address", {8'b0, cap[23:0]}, {8'b0, VECS[i].adr});
            check("R6 sclk period", 32'(per), 32'(2 * (int'(VECS[i].div) + 1)));
            check("R5 idle after", {30'b0, spi_cs_n, spi_sclk}, 32'h2);
            pop_check("R7 R8 data", VECS[i].adr, int'(VECS[i].cnt) + 1);
        end
        wr(8'h40, 32'h1);

        // R10 busy and R11 ignored second command
        f0 = frames;
        start_read(24'h000040, 16);
        rd(8'h34, r); check("R10 busy", r, 32'h1);
        wr(8'h24, 32'hAB);
        rd(8'h24, r); check("R11 opcode kept", r, 32'h03);
        wait_idle();
        rd(8'h34, r); check("R10 idle", r, 32'h0);
        check("R11 frames", 32'(frames - f0), 32'h1);
        pop_check("R11 data", 24'h000040, 16);

        // R9 empty read waits
        start_read(24'h000777, 4);
        apb(1'b0, 8'h2C, '0, r, w);
        check("R9 word", r, exp_word(24'h000777, 4, 0));
        check("R9 waited", 32'(w > 0), 32'h1);
        wait_idle();

        // R12 flush
        start_read(24'h001000, 8);
        wait_idle();
        wr(8'h30, 32'h2);
        start_read(24'h002000, 4);
        wait_idle();
        rd(8'h2C, r); check("R12 flushed", r, exp_word(24'h002000, 4, 0));

        // R13 full FIFO stall
        start_read(24'h000100, 24);
        repeat (1500) @(negedge pclk);
        rd(8'h34, r); check("R13 still busy", r, 32'h1);
        check("R13 stalled at", 32'(bitcnt), 32'd160);
        check("R13 sclk low", {31'b0, spi_sclk}, 32'h0);
        pop_check("R13 data", 24'h000100, 24);
        wait_idle();

        // R4 command-only, mode 0
        hdr_bits = 8;
        wr(8'h20, 32'h4000_0000);
        wr(8'h24, 32'h9F);
        wait_idle();
        check("R4 bits", 32'(bitcnt), 32'd8);
        check("R4 opcode", {24'b0, cap[7:0]}, 32'h9F);
        check("R4 cs high", {31'b0, spi_cs_n}, 32'h1);
        hdr_bits = 32;

        done = 1;
        summary();
        $finish;
    end
endmodule